// File: doc/BRIEF.md
# Rotated Binary Descriptor Generator

This block builds a 256-bit binary signature for one keypoint. It receives the smoothed 37×37 pixel patch centred on the keypoint and a quantised orientation. For each of 256 tests it takes a pair of sample points from a fixed pseudo-random pattern, rotates both points by the orientation, clips them to the patch, and compares the two pixel intensities. The result of each comparison is one bit of the signature. Rotating the pattern makes the signature stable under in-plane rotation of the image.

The rotated pattern coordinates are produced by constant logic indexed by orientation bin and test number; no rotation arithmetic runs on pixel data. The tests are evaluated `TESTS_PER_CYC` at a time, so one signature takes 256/`TESTS_PER_CYC` cycles. A request is a valid/ready handshake. The block accepts one request at a time and drops `req_ready` while it works, so a request held during that time waits for the next idle cycle. The patch must stay unchanged from the accept edge until `desc_valid` is seen. The result side has no back-pressure: `desc_valid` is a single-cycle strobe, and the consumer must take `desc_bits` in that cycle.

Top module: `rot_desc_gen`

## Requirements
- R1: While `rst_n` is low and right after it, `req_ready` is 1 and `desc_valid` is 0.
- R2: A test gives 1 when the intensity at its first point is greater than or equal to the intensity at its second point, and gives 0 when it is strictly smaller. A uniform patch therefore gives all ones.
- R3: Test t (0..255) is written to `desc_bits[t]`, so the first test is the least significant bit.
- R4: The unrotated offsets of test t are b(t,w) = ((7t² + 13t + 29w + 3w·floor(t/4)) mod 31) − 15. Here w=0 is x1, w=1 is y1, w=2 is x2 and w=3 is y2. A point at offset (dx,dy) reads the pixel at row dy+18, column dx+18. Pixel (row r, column c) sits at `win_pix[(37r+c)*8 +: 8]`.
- R5: `req_bin` k (0..29) stands for an angle of 12k degrees. Take C = round(256·cos) and S = round(256·sin) of that angle. Each point becomes x' = floor((C·x − S·y + 128)/256) and y' = floor((S·x + C·y + 128)/256). Each coordinate is then clipped to the range −18..18.
- R6: A request is accepted on an edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the accept edge until the last test group has been written. A request presented during that time has no effect on the signature being produced.
- R7: If a request is accepted at edge n, `desc_valid` is 1 for exactly the cycle that follows edge n + 256/`TESTS_PER_CYC`. In that cycle `desc_bits` holds the complete signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request to start a signature |
| req_ready | output | 1 | Block idle, request can be taken |
| req_bin | input | 5 | Orientation bin 0..29, sampled on accept |
| win_pix | input | 37*37*PIX_W | Patch pixels, row-major, row 0 at the low end |
| desc_valid | output | 1 | One-cycle strobe, signature complete |
| desc_bits | output | 256 | Signature, test t at bit t |

## Verification
The assertions take two things for granted: an accepted orientation bin is below 30, and the latched bin stays fixed for the whole run. They also rely on the patch being held steady over the same span, although no property can see that directly. The stimulus changes the patch only when the reference model shows the block idle. It draws bins only from 0..29. It holds a competing request with a different bin during a run, which checks that this request is dropped. It also holds `req_valid` high across two runs back to back.

// File: rtl/rdg_pkg.sv
package rdg_pkg;
  localparam int WIN    = 37;
  localparam int HALF   = 18;
  localparam int NBINS  = 30;
  localparam int NTESTS = 256;
  localparam int BIN_W  = 5;

  // cos / sin of 12k degrees scaled by 256, k = 0..29
  function automatic int trig_q8(input int k, input bit want_sin);
    int idx;
    int v;
    idx = k % 15;
    v = 0;
    if (want_sin) begin
      case (idx)
        0: v = 0;     1: v = 53;    2: v = 104;   3: v = 150;  4: v = 190;
        5: v = 222;   6: v = 243;   7: v = 255;   8: v = 255;  9: v = 243;
        10: v = 222;  11: v = 190;  12: v = 150;  13: v = 104; 14: v = 53;
        default: v = 0;
      endcase
    end else begin
      case (idx)
        0: v = 256;   1: v = 250;   2: v = 234;   3: v = 207;  4: v = 171;
        5: v = 128;   6: v = 79;    7: v = 27;    8: v = -27;  9: v = -79;
        10: v = -128; 11: v = -171; 12: v = -207; 13: v = -234; 14: v = -250;
        default: v = 0;
      endcase
    end
    return (k >= 15) ? -v : v;
  endfunction

  // unrotated pattern offset, w: 0=x1 1=y1 2=x2 3=y2
  function automatic int base_off(input int t, input int w);
    return ((t*t*7 + t*13 + w*29 + (t >> 2)*w*3) % 31) - 15;
  endfunction

  // rotated, rounded and clipped coordinate of one sample point
  function automatic int rot_clip(input int bin, input int t, input bit second, input bit is_y);
    int x, y, c, s, v;
    x = base_off(t, second ? 2 : 0);
    y = base_off(t, second ? 3 : 1);
    c = trig_q8(bin, 1'b0);
    s = trig_q8(bin, 1'b1);
    v = is_y ? (s*x + c*y) : (c*x - s*y);
    v = (v + 128) >>> 8;
    if (v > HALF) v = HALF;
    if (v < -HALF) v = -HALF;
    return v;
  endfunction
endpackage

// File: rtl/rdg_ctrl.sv
module rdg_ctrl #(
  parameter int GROUPS = 32,
  localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  output logic          busy,
  output logic [GW-1:0] grp_idx,
  output logic          done
);
  localparam logic [GW-1:0] LAST = GW'(GROUPS - 1);

  assign req_ready = !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      grp_idx <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        if (grp_idx == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
        grp_idx <= grp_idx + 1'b1;
      end else if (req_valid) begin
        busy    <= 1'b1;
        grp_idx <= '0;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && $past(grp_idx) == LAST && !busy)); // R7
  AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && grp_idx != LAST) |=> (busy && grp_idx == $past(grp_idx) + 1'b1)); // R6
endmodule

// File: rtl/rdg_lane.sv
module rdg_lane #(
  parameter int PIX_W = 8,
  localparam int WBITS = rdg_pkg::WIN * rdg_pkg::WIN * PIX_W
) (
  input  logic [rdg_pkg::BIN_W-1:0] bin,
  input  logic [7:0]                test_idx,
  input  logic [WBITS-1:0]          win,
  output logic                      bit_o
);
  import rdg_pkg::*;

  int ax, ay, bx, by, addr_a, addr_b;
  logic [PIX_W-1:0] pa, pb;

  always_comb begin
    ax = rot_clip(int'(bin), int'(test_idx), 1'b0, 1'b0);
    ay = rot_clip(int'(bin), int'(test_idx), 1'b0, 1'b1);
    bx = rot_clip(int'(bin), int'(test_idx), 1'b1, 1'b0);
    by = rot_clip(int'(bin), int'(test_idx), 1'b1, 1'b1);
    addr_a = (ay + HALF) * WIN + (ax + HALF);
    addr_b = (by + HALF) * WIN + (bx + HALF);
    pa = win[addr_a*PIX_W +: PIX_W];
    pb = win[addr_b*PIX_W +: PIX_W];
    bit_o = (pa >= pb);
  end
endmodule

// File: rtl/rdg_accum.sv
module rdg_accum #(
  parameter int P = 8,
  localparam int GROUPS = rdg_pkg::NTESTS / P,
  localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [GW-1:0]             grp_idx,
  input  logic [P-1:0]              bits,
  output logic [rdg_pkg::NTESTS-1:0] desc
);
  always_ff @(posedge clk) begin
    if (!rst_n) desc <= '0;
    else if (wr_en) desc[grp_idx*P +: P] <= bits;
  end
endmodule

// File: rtl/rot_desc_gen.sv
module rot_desc_gen #(
  parameter int PIX_W = 8,
  parameter int TESTS_PER_CYC = 8,
  localparam int GROUPS = rdg_pkg::NTESTS / TESTS_PER_CYC,
  localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int WBITS = rdg_pkg::WIN * rdg_pkg::WIN * PIX_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [rdg_pkg::BIN_W-1:0]  req_bin,
  input  logic [WBITS-1:0]           win_pix,
  output logic                       desc_valid,
  output logic [rdg_pkg::NTESTS-1:0] desc_bits
);
  import rdg_pkg::*;

  logic                 busy;
  logic [GW-1:0]        grp_idx;
  logic [BIN_W-1:0]     bin_q;
  logic [TESTS_PER_CYC-1:0] grp_bits;

  rdg_ctrl #(.GROUPS(GROUPS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .busy(busy), .grp_idx(grp_idx), .done(desc_valid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) bin_q <= '0;
    else if (req_valid && req_ready) bin_q <= req_bin;
  end

  for (genvar g = 0; g < TESTS_PER_CYC; g++) begin : g_lane
    logic [7:0] tidx;
    assign tidx = 8'(int'(grp_idx) * TESTS_PER_CYC + g);
    rdg_lane #(.PIX_W(PIX_W)) u_lane (
      .bin(bin_q), .test_idx(tidx), .win(win_pix), .bit_o(grp_bits[g])
    );
  end

  rdg_accum #(.P(TESTS_PER_CYC)) u_acc (
    .clk(clk), .rst_n(rst_n), .wr_en(busy), .grp_idx(grp_idx),
    .bits(grp_bits), .desc(desc_bits)
  );

  AST_BIN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> (int'(req_bin) < NBINS)); // R5
  AST_BIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(bin_q)); // R6
  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> req_ready); // R7
endmodule

// File: tb/rot_desc_gen_bench.sv
module rot_desc_gen_bench;
  localparam int P = 8;
  localparam int G = 256 / P;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [4:0] req_bin = '0;
  logic req_ready, desc_valid;
  logic [255:0] desc_bits;
  logic [7:0] pix [37][37];
  logic [37*37*8-1:0] win_flat;

  int vectors = 0, fails = 0, cycles = 0;
  string cur_tag = "R3";

  always #5 clk = ~clk;

  always_comb
    for (int r = 0; r < 37; r++)
      for (int c = 0; c < 37; c++)
        win_flat[(37*r+c)*8 +: 8] = pix[r][c];

  rot_desc_gen #(.PIX_W(8), .TESTS_PER_CYC(P)) u_rot_desc_gen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bin(req_bin), .win_pix(win_flat), .desc_valid(desc_valid), .desc_bits(desc_bits)
  );

  // reference math written from the requirements
  function automatic int ref_off(int t, int w);
    int h;
    h = 7*t*t + 13*t + 29*w + 3*w*(t/4);
    return (h % 31) - 15;
  endfunction

  function automatic int ref_coord(int bin, int t, int pt, bit want_y);
    real ang;
    int c, s, x, y, v;
    ang = 12.0 * bin * 3.14159265358979 / 180.0;
    c = $rtoi($floor(256.0 * $cos(ang) + 0.5));
    s = $rtoi($floor(256.0 * $sin(ang) + 0.5));
    x = ref_off(t, 2*pt);
    y = ref_off(t, 2*pt + 1);
    v = want_y ? (s*x + c*y + 128) : (c*x - s*y + 128);
    v = (v >= 0) ? v / 256 : -((-v + 255) / 256);
    return (v > 18) ? 18 : ((v < -18) ? -18 : v);
  endfunction

  function automatic logic [255:0] ref_desc(int bin);
    logic [255:0] d;
    for (int t = 0; t < 256; t++) begin
      int a_r, a_c, b_r, b_c;
      a_c = ref_coord(bin, t, 0, 0) + 18;
      a_r = ref_coord(bin, t, 0, 1) + 18;
      b_c = ref_coord(bin, t, 1, 0) + 18;
      b_r = ref_coord(bin, t, 1, 1) + 18;
      d[t] = (pix[a_r][a_c] >= pix[b_r][b_c]);
    end
    return d;
  endfunction

  // cycle model
  logic m_busy = 1'b0, m_done = 1'b0;
  int m_left = 0;
  logic [255:0] exp_desc = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_done <= 1'b0; m_left <= 0;
    end else begin
      m_done <= 1'b0;
      if (m_busy) begin
        if (m_left == 1) begin m_busy <= 1'b0; m_done <= 1'b1; end
        m_left <= m_left - 1;
      end else if (req_valid) begin
        m_busy <= 1'b1;
        m_left <= G;
        exp_desc <= ref_desc(int'(req_bin));
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst_n) begin
      check(req_ready === 1'b1, "R1 ready in reset", 256'(req_ready), 256'(1));
      check(desc_valid === 1'b0, "R1 valid in reset", 256'(desc_valid), 256'(0));
    end else begin
      check(req_ready === !m_busy, "R6 ready", 256'(req_ready), 256'(!m_busy));
      check(desc_valid === m_done, "R7 valid strobe", 256'(desc_valid), 256'(m_done));
      if (m_done) check(desc_bits === exp_desc, cur_tag, desc_bits, exp_desc);
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic fill_random();
    for (int r = 0; r < 37; r++)
      for (int c = 0; c < 37; c++) pix[r][c] = 8'($urandom_range(0, 255));
  endtask

  task automatic run_req(input int bin);
    @(negedge clk);
    req_valid = 1'b1; req_bin = 5'(bin);
    @(negedge clk);
    req_valid = 1'b0;
    while (!desc_valid) @(negedge clk);
  endtask

  initial begin
    void'($urandom(7));
    fill_random();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready === 1'b1 && desc_valid === 1'b0, "R1 after reset",
          {254'(0), req_ready, desc_valid}, 256'(2));

    cur_tag = "R3 R4 bin0 random";
    run_req(0);
    fill_random(); cur_tag = "R5 bin7 random";
    run_req(7);
    fill_random(); cur_tag = "R5 bin29 random";
    run_req(29);

    // uniform patch gives all ones
    for (int r = 0; r < 37; r++) for (int c = 0; c < 37; c++) pix[r][c] = 8'h55;
    cur_tag = "R2 uniform";
    run_req(11);
    check(desc_bits === '1, "R2 uniform all ones", desc_bits, '1);

    // gradient patch, opposite bins, clipping at the edges
    for (int r = 0; r < 37; r++) for (int c = 0; c < 37; c++) pix[r][c] = 8'(r*5 + c);
    cur_tag = "R5 gradient bin0";
    run_req(0);
    cur_tag = "R5 gradient bin15";
    run_req(15);

    // competing request during a run is ignored
    fill_random(); cur_tag = "R6 ignored request";
    @(negedge clk);
    req_valid = 1'b1; req_bin = 5'd3;
    @(negedge clk);
    req_bin = 5'd20;
    repeat (G - 4) @(negedge clk);
    req_valid = 1'b0;
    while (!desc_valid) @(negedge clk);

    // back to back with valid held high
    fill_random(); cur_tag = "R7 back to back";
    @(negedge clk);
    req_valid = 1'b1; req_bin = 5'd22;
    repeat (2*G + 4) @(negedge clk);
    req_valid = 1'b0;
    repeat (G + 4) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule